// File: doc/BRIEF.md
# Serial-Entry Two-Operand Adder with Hex Display

The block accepts two small unsigned operands through one shared narrow data port, one operand per clock cycle. Each rising edge moves the port value into a first holding register and moves the old content of that register into a second one. The two held values are added by a chain of full adders. The sum appears on a binary output one bit wider than an operand, and a seven-segment decoder shows it as a hexadecimal glyph.

To add two numbers, drive the first operand for one edge and the second for the next edge. After the second edge the sum output and the display show their total. Reset is sampled only on a clock edge, and it empties both holding registers.

Top module: `opsum_display_unit`

## Requirements
- R1: When `rst` is high at a rising edge, both holding registers clear, so after that edge `sum_out` is 0 and `seg_n` shows the glyph 0 (`7'h40`).
- R2: Reset acts only at a clock edge. Raising `rst` between edges leaves `sum_out` and `seg_n` unchanged until the next rising edge.
- R3: With `rst` low, each rising edge loads `din` into the first register. After a reset edge followed by one edge with value A, `sum_out` equals A.
- R4: With `rst` low, each rising edge moves the previous first-register value into the second register. After edges carrying A and then B, `sum_out` equals A + B.
- R5: `sum_out` is the full 4-bit unsigned sum, with the carry out in bit 3. The largest value is 7 + 7 = 14.
- R6: `seg_n` is active-low with `seg_n[0]`=a through `seg_n[6]`=g. It shows the hex glyph of `sum_out`, with lit segments as follows: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 acdefg, 7 abc, 8 abcdefg, 9 abcdfg, A abcefg, b cdefg, C adef, d bcdeg, E adefg, F aefg.
- R7: If `din` holds the value V across two or more edges with `rst` low, `sum_out` equals 2·V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 3 | Shared operand input |
| sum_out | output | 4 | Sum of the two held operands |
| seg_n | output | 7 | Active-low segments, bit 0 = a through bit 6 = g |

## Verification
The bench builds the block with its default 3-bit operand width and active-low display polarity. At this width every one of the 64 operand pairs can be applied in sequence, which drives every reachable sum from 0 to 14 and every glyph except F. A random phase with occasional resets then checks the two-register pipeline against a separate model, including resets that arrive between an operand and its partner.

// File: rtl/osd_pkg.sv
`timescale 1ns/1ps
package osd_pkg;

  // Segment vector: bit 0 = a ... bit 6 = g, 1 means lit
  typedef logic [6:0] seg_t;

  // Full adder arithmetic, kept as functions so the cell stays structural
  function automatic logic fa_sum(input logic a, input logic b, input logic ci);
    return a ^ b ^ ci;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic ci);
    return (a & b) | (ci & (a ^ b));
  endfunction

  // Hex glyph lookup, lit-high form
  function automatic seg_t hex_lit(input logic [3:0] v);
    seg_t s;
    case (v)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/osd_full_adder.sv
`timescale 1ns/1ps
module osd_full_adder
  import osd_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);

  assign s  = fa_sum(a, b, ci);
  assign co = fa_carry(a, b, ci);

endmodule

// File: rtl/osd_ripple_adder.sv
`timescale 1ns/1ps
module osd_ripple_adder #(
  parameter int W = 3
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W:0]   total
);

  // carry[i] enters bit i; carry[W] is the final carry out
  logic [W:0]   carry;
  logic [W-1:0] bit_sum;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_cell
    osd_full_adder u_fa (
      .a  (x[i]),
      .b  (y[i]),
      .ci (carry[i]),
      .s  (bit_sum[i]),
      .co (carry[i+1])
    );
  end

  assign total = {carry[W], bit_sum};

endmodule

// File: rtl/osd_operand_stage.sv
`timescale 1ns/1ps
module osd_operand_stage #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] newest,
  output logic [W-1:0] older
);

  // Two-deep shift chain, synchronous clear
  always_ff @(posedge clk) begin
    if (rst) begin
      newest <= '0;
      older  <= '0;
    end else begin
      newest <= d;
      older  <= newest;
    end
  end

endmodule

// File: rtl/osd_seg_decoder.sv
`timescale 1ns/1ps
module osd_seg_decoder
  import osd_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic [3:0] nibble,
  output logic [6:0] seg
);

  seg_t lit;

  assign lit = hex_lit(nibble);

  if (ACTIVE_LOW) begin : g_low
    assign seg = ~lit;
  end else begin : g_high
    assign seg = lit;
  end

endmodule

// File: rtl/opsum_display_unit.sv
`timescale 1ns/1ps
module opsum_display_unit #(
  parameter int OPW        = 3,
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] din,
  output logic [OPW:0]   sum_out,
  output logic [6:0]     seg_n
);

  localparam int SUMW = OPW + 1;

  // Named internal wires
  logic [OPW-1:0]  stage_new;
  logic [OPW-1:0]  stage_old;
  logic [SUMW-1:0] adder_total;
  logic [3:0]      disp_nibble;

  osd_operand_stage #(.W(OPW)) u_stage (
    .clk    (clk),
    .rst    (rst),
    .d      (din),
    .newest (stage_new),
    .older  (stage_old)
  );

  osd_ripple_adder #(.W(OPW)) u_add (
    .x     (stage_new),
    .y     (stage_old),
    .total (adder_total)
  );

  // Fit the sum into one display digit
  if (SUMW >= 4) begin : g_trunc
    assign disp_nibble = adder_total[3:0];
  end else begin : g_pad
    assign disp_nibble = {{(4-SUMW){1'b0}}, adder_total};
  end

  osd_seg_decoder #(.ACTIVE_LOW(ACTIVE_LOW)) u_dec (
    .nibble (disp_nibble),
    .seg    (seg_n)
  );

  assign sum_out = adder_total;

endmodule

// File: rtl/osd_checker.sv
`timescale 1ns/1ps
module osd_checker #(
  parameter int OPW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic [OPW-1:0] din,
  input logic [OPW:0]   sum_out,
  input logic [6:0]     seg_n
);

  localparam int SUMW = OPW + 1;
  localparam int MAXS = 2 * ((1 << OPW) - 1);

  // Clean edges since the last reset edge, saturating at 2
  logic [1:0] warm = 2'd0;
  always_ff @(posedge clk) begin
    if (rst)            warm <= 2'd0;
    else if (warm != 2) warm <= warm + 2'd1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sum_out == '0 && seg_n == 7'h40)); // R1

  AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd1) |-> (sum_out == SUMW'($past(din)))); // R3

  AST_TWO_STAGE: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (sum_out == SUMW'($past(din)) + SUMW'($past(din, 2)))); // R4

  AST_SUM_CAP: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0) |-> (int'(sum_out) <= MAXS)); // R5

  AST_GLYPH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0 && sum_out == '0) |-> (seg_n == 7'h40)); // R6

  AST_GLYPH_EIGHT: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0 && sum_out == SUMW'(8)) |-> (seg_n == 7'h00)); // R6

endmodule

bind opsum_display_unit osd_checker #(.OPW(OPW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .din     (din),
  .sum_out (sum_out),
  .seg_n   (seg_n)
);

// File: tb/opsum_display_unit_test.sv
`timescale 1ns/1ps
module opsum_display_unit_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] din = 3'd0;
  logic [3:0] sum_out;
  logic [6:0] seg_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Bench model of the two held operands
  logic [2:0] m_new = 3'd0;
  logic [2:0] m_old = 3'd0;

  always #2.5 clk = ~clk;

  opsum_display_unit uut (
    .clk     (clk),
    .rst     (rst),
    .din     (din),
    .sum_out (sum_out),
    .seg_n   (seg_n)
  );

  // Lit set written as letters, turned into an active-low vector
  function automatic logic [6:0] from_letters(string s);
    logic [6:0] lit = 7'd0;
    for (int i = 0; i < s.len(); i++) lit[s[i] - 8'h61] = 1'b1;
    return ~lit;
  endfunction

  function automatic logic [6:0] exp_seg(int v);
    case (v)
      0: return from_letters("abcdef");
      1: return from_letters("bc");
      2: return from_letters("abdeg");
      3: return from_letters("abcdg");
      4: return from_letters("bcfg");
      5: return from_letters("acdfg");
      6: return from_letters("acdefg");
      7: return from_letters("abc");
      8: return from_letters("abcdefg");
      9: return from_letters("abcdfg");
      10: return from_letters("abcefg");
      11: return from_letters("cdefg");
      12: return from_letters("adef");
      13: return from_letters("bcdeg");
      14: return from_letters("adefg");
      default: return from_letters("aefg");
    endcase
  endfunction

  function automatic int exp_sum(int a, int b);
    return a + b;
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  // Drive at the falling edge, then sample 1 ns after the rising edge
  task automatic step(input logic r, input logic [2:0] v);
    @(negedge clk);
    rst = r;
    din = v;
    @(posedge clk);
    if (r) begin
      m_new = 3'd0;
      m_old = 3'd0;
    end else begin
      m_old = m_new;
      m_new = v;
    end
    #1;
  endtask

  task automatic check_model(string req);
    int e;
    e = exp_sum(int'(m_new), int'(m_old));
    check(req, int'(sum_out), e);
    check({req, "/R6"}, int'(seg_n), int'(exp_seg(e)));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd20250611;
    void'($urandom(seed));

    // R1: reset state
    step(1'b1, 3'd5);
    step(1'b1, 3'd6);
    check("R1 sum", int'(sum_out), 0);
    check("R1 seg", int'(seg_n), 7'h40);

    // R3: one operand after reset
    step(1'b0, 3'd5);
    check("R3 first load", int'(sum_out), 5);
    // R4: second operand
    step(1'b0, 3'd6);
    check("R4 pair 5+6", int'(sum_out), 11);
    check("R6 glyph b", int'(seg_n), int'(from_letters("cdefg")));

    // R5: maximum sum
    step(1'b0, 3'd7);
    step(1'b0, 3'd7);
    check("R5 max sum", int'(sum_out), 14);
    check("R5 carry bit", int'(sum_out[3]), 1);
    check("R6 glyph E", int'(seg_n), int'(from_letters("adefg")));

    // R2: reset raised mid-cycle has no effect before the edge
    @(negedge clk);
    rst = 1'b1;
    #1;
    check("R2 sum held", int'(sum_out), 14);
    check("R2 seg held", int'(seg_n), int'(from_letters("adefg")));
    @(posedge clk);
    m_new = 3'd0;
    m_old = 3'd0;
    #1;
    check("R2 cleared at edge", int'(sum_out), 0);

    // R7: held input
    step(1'b0, 3'd3);
    step(1'b0, 3'd3);
    step(1'b0, 3'd3);
    check("R7 doubled", int'(sum_out), 6);

    // R4/R6: every operand pair in sequence
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        step(1'b0, 3'(a));
        step(1'b0, 3'(b));
        check("R4 sweep", int'(sum_out), exp_sum(a, b));
        check("R6 sweep", int'(seg_n), int'(exp_seg(exp_sum(a, b))));
      end
    end

    // Random phase with occasional reset
    for (int n = 0; n < 400; n++) begin
      logic r;
      r = (($urandom() % 16) == 0);
      step(r, 3'($urandom() % 8));
      if (r) check("R1 random reset", int'(sum_out), 0);
      else   check_model("R4 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule